// File: doc/BRIEF.md
# Miss-Aware Victim Selector

This block is the replacement engine for one set-associative cache level. For every cache access it is told which instruction issued the access (as a hashed program-counter signature), which set was addressed, whether the lookup hit, and, on a hit, which way hit. It learns per instruction whether that instruction's accesses tend to hit or to miss, and it keeps that learned opinion beside every line it installs or refreshes.

On a miss it names a victim way one cycle later, and it records the fill into that way in its own line state. Empty ways are used first. Once the set is full, lines last touched by instructions expected to miss are evicted before lines from instructions expected to hit. A per-set age order breaks ties. Tag and data storage live outside the block. The surrounding cache controller hashes the program counter and writes the fill into the way that the block reports.

Top module: `miss_aware_victim_sel`

## Requirements
- R1: After reset every way is invalid. While a set still has an invalid way, a miss picks the lowest-numbered invalid way with reason code 0. So the first WAYS misses to a fresh set return ways 0, 1, ..., WAYS-1 in that order. The default is 16 ways.
- R2: The learning table holds one 3-bit saturating counter for each value of a 10-bit signature, and every counter resets to 4. A hit adds one and stops at 7. A miss subtracts one and stops at 0.
- R3: Each accepted access raises pred_valid on the next cycle. With it comes pred_hit, equal to the most significant bit of that signature's counter as it stood before this access trained it (1 means hit-friendly).
- R4: A miss raises vic_valid on the next cycle together with vic_way and vic_reason. A hit never raises vic_valid, and both valid outputs are 0 after reset.
- R5: When every way of the set is valid and at least one line carries a miss-predicted flag (0), the victim is the miss-predicted line with the largest age rank, with reason code 1.
- R6: When every way is valid and all flags are 1, the victim is the line with the largest age rank, with reason code 2.
- R7: Each set keeps an age rank per way that starts equal to the way number. The touched line gets rank 0, and every line whose rank was below the touched line's old rank ages by one.
- R8: The victim of a miss becomes valid with flag equal to that access's pred_hit. A hit rewrites the flag of the hit way with pred_hit. In both cases the line then becomes the youngest (R7).
- R9: acc_way has no effect on a miss. A cycle with acc_valid low changes no state and raises neither valid output. Each set's line state is changed only by accesses to that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_sig | input | SIG_W | Hashed program-counter signature of the issuing instruction |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 when the lookup hit, 0 when it missed |
| acc_way | input | WAY_W | Way that hit (used only on hits) |
| pred_valid | output | 1 | Prediction for the previous cycle's access is available |
| pred_hit | output | 1 | Predicted hit-friendly (1) or miss-prone (0) |
| vic_valid | output | 1 | Victim for the previous cycle's miss is available |
| vic_way | output | WAY_W | Chosen victim way |
| vic_reason | output | 2 | 0 invalid way, 1 miss-predicted line, 2 oldest line |

## Verification
A wrong counter value shows up only through pred_hit, and only once its most significant bit is misread. It can therefore stay hidden for several accesses of the same signature, and the bench drives runs of hits and misses long enough to cross both saturation limits. A corrupted flag or age rank stays invisible until the set is full and a miss asks for a victim. At that point vic_way or vic_reason differs on the cycle after the miss. For this reason the bench fills sets completely and compares every victim it receives against an arithmetic model over a long mixed stream.

// File: rtl/evp_pkg.sv
package evp_pkg;

    localparam int DEF_WAYS  = 16;
    localparam int DEF_SETS  = 64;
    localparam int DEF_SIG_W = 10;
    localparam int DEF_CTR_W = 3;

    typedef enum logic [1:0] {
        VR_INVALID   = 2'd0,
        VR_PREDICTED = 2'd1,
        VR_OLDEST    = 2'd2
    } vic_reason_e;

    typedef struct packed {
        logic        hit;
        logic        friendly;
    } access_view_t;

endpackage

// File: rtl/evp_counter_table.sv
module evp_counter_table #(
    parameter int SIG_W = evp_pkg::DEF_SIG_W,
    parameter int CTR_W = evp_pkg::DEF_CTR_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             upd_en,
    input  logic [SIG_W-1:0] upd_sig,
    input  logic             upd_up,
    output logic             rd_friendly
);
    localparam int DEPTH = 1 << SIG_W;
    localparam logic [CTR_W-1:0] CTR_MAX = {CTR_W{1'b1}};
    localparam logic [CTR_W-1:0] CTR_MID = CTR_W'(1 << (CTR_W - 1));

    logic [CTR_W-1:0] ctr [DEPTH];
    logic [CTR_W-1:0] cur;

    assign cur         = ctr[upd_sig];
    assign rd_friendly = cur[CTR_W-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ctr[i] <= CTR_MID;
        end else if (upd_en) begin
            if (upd_up && cur != CTR_MAX)
                ctr[upd_sig] <= cur + 1'b1;
            else if (!upd_up && cur != '0)
                ctr[upd_sig] <= cur - 1'b1;
        end
    end
endmodule

// File: rtl/evp_line_state.sv
module evp_line_state #(
    parameter int WAYS = evp_pkg::DEF_WAYS,
    parameter int SETS = evp_pkg::DEF_SETS,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [SET_W-1:0]             set_idx,
    input  logic                         wr_en,
    input  logic [WAY_W-1:0]             wr_way,
    input  logic                         wr_flag,
    output logic [WAYS-1:0]              set_valid,
    output logic [WAYS-1:0]              set_flag,
    output logic [WAYS-1:0][WAY_W-1:0]   set_rank
);
    typedef struct packed {
        logic             valid;
        logic             flag;
        logic [WAY_W-1:0] rank;
    } line_t;

    line_t lines [SETS][WAYS];
    logic [WAY_W-1:0] touched_rank;

    always_comb begin
        for (int w = 0; w < WAYS; w++) begin
            set_valid[w] = lines[set_idx][w].valid;
            set_flag[w]  = lines[set_idx][w].flag;
            set_rank[w]  = lines[set_idx][w].rank;
        end
    end

    assign touched_rank = lines[set_idx][wr_way].rank;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    lines[s][w].valid <= 1'b0;
                    lines[s][w].flag  <= 1'b0;
                    lines[s][w].rank  <= WAY_W'(w);
                end
            end
        end else if (wr_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == wr_way) begin
                    lines[set_idx][w].valid <= 1'b1;
                    lines[set_idx][w].flag  <= wr_flag;
                    lines[set_idx][w].rank  <= '0;
                end else if (lines[set_idx][w].rank < touched_rank) begin
                    lines[set_idx][w].rank <= lines[set_idx][w].rank + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/evp_victim_pick.sv
module evp_victim_pick #(
    parameter int WAYS = evp_pkg::DEF_WAYS,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]             valid,
    input  logic [WAYS-1:0]             flag,
    input  logic [WAYS-1:0][WAY_W-1:0]  rank,
    output logic [WAY_W-1:0]            pick_way,
    output evp_pkg::vic_reason_e        pick_reason
);
    logic             any_inv, any_mp;
    logic [WAY_W-1:0] inv_way, mp_way, mp_rank, old_way, old_rank;

    always_comb begin
        any_inv  = 1'b0;
        inv_way  = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                any_inv = 1'b1;
                inv_way = WAY_W'(i);
            end
        end
        any_mp   = 1'b0;
        mp_way   = '0;
        mp_rank  = '0;
        old_way  = '0;
        old_rank = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (!flag[i] && (!any_mp || rank[i] > mp_rank)) begin
                any_mp  = 1'b1;
                mp_way  = WAY_W'(i);
                mp_rank = rank[i];
            end
            if (rank[i] >= old_rank) begin
                old_way  = WAY_W'(i);
                old_rank = rank[i];
            end
        end
        if (any_inv) begin
            pick_way    = inv_way;
            pick_reason = evp_pkg::VR_INVALID;
        end else if (any_mp) begin
            pick_way    = mp_way;
            pick_reason = evp_pkg::VR_PREDICTED;
        end else begin
            pick_way    = old_way;
            pick_reason = evp_pkg::VR_OLDEST;
        end
    end
endmodule

// File: rtl/miss_aware_victim_sel.sv
module miss_aware_victim_sel #(
    parameter int WAYS  = evp_pkg::DEF_WAYS,
    parameter int SETS  = evp_pkg::DEF_SETS,
    parameter int SIG_W = evp_pkg::DEF_SIG_W,
    parameter int CTR_W = evp_pkg::DEF_CTR_W,
    localparam int WAY_W = $clog2(WAYS),
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [SIG_W-1:0] acc_sig,
    input  logic [SET_W-1:0] acc_set,
    input  logic             acc_hit,
    input  logic [WAY_W-1:0] acc_way,
    output logic             pred_valid,
    output logic             pred_hit,
    output logic             vic_valid,
    output logic [WAY_W-1:0] vic_way,
    output logic [1:0]       vic_reason
);
    evp_pkg::access_view_t           view;
    evp_pkg::vic_reason_e            pick_reason;
    logic [WAY_W-1:0]                pick_way, wr_way;
    logic [WAYS-1:0]                 set_valid, set_flag;
    logic [WAYS-1:0][WAY_W-1:0]      set_rank;

    assign view.hit = acc_hit;

    evp_counter_table #(.SIG_W(SIG_W), .CTR_W(CTR_W)) u_ctr (
        .clk         (clk),
        .rst         (rst),
        .upd_en      (acc_valid),
        .upd_sig     (acc_sig),
        .upd_up      (view.hit),
        .rd_friendly (view.friendly)
    );

    evp_line_state #(.WAYS(WAYS), .SETS(SETS)) u_lines (
        .clk       (clk),
        .rst       (rst),
        .set_idx   (acc_set),
        .wr_en     (acc_valid),
        .wr_way    (wr_way),
        .wr_flag   (view.friendly),
        .set_valid (set_valid),
        .set_flag  (set_flag),
        .set_rank  (set_rank)
    );

    evp_victim_pick #(.WAYS(WAYS)) u_pick (
        .valid       (set_valid),
        .flag        (set_flag),
        .rank        (set_rank),
        .pick_way    (pick_way),
        .pick_reason (pick_reason)
    );

    assign wr_way = view.hit ? acc_way : pick_way;

    always_ff @(posedge clk) begin
        if (rst) begin
            pred_valid <= 1'b0;
            pred_hit   <= 1'b0;
            vic_valid  <= 1'b0;
            vic_way    <= '0;
            vic_reason <= 2'd0;
        end else begin
            pred_valid <= acc_valid;
            pred_hit   <= acc_valid & view.friendly;
            vic_valid  <= acc_valid & ~view.hit;
            if (acc_valid && !view.hit) begin
                vic_way    <= pick_way;
                vic_reason <= pick_reason;
            end
        end
    end
endmodule

// File: rtl/evp_checker.sv
module evp_checker (
    input logic       clk,
    input logic       rst,
    input logic       acc_valid,
    input logic       acc_hit,
    input logic       pred_valid,
    input logic       vic_valid,
    input logic [1:0] vic_reason
);
    assert_pred_after_access_R3: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> pred_valid);

    assert_pred_needs_access_R3: assert property (@(posedge clk) disable iff (rst)
        pred_valid |-> $past(acc_valid));

    assert_victim_after_miss_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !acc_hit) |=> vic_valid);

    assert_no_victim_on_hit_R4: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_hit) |=> !vic_valid);

    assert_victim_with_pred_R4: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> pred_valid);

    assert_reason_code_R1: assert property (@(posedge clk) disable iff (rst)
        vic_valid |-> (vic_reason != 2'd3));
endmodule

bind miss_aware_victim_sel evp_checker u_chk (.*);

// File: tb/miss_aware_victim_sel_test.sv
module miss_aware_victim_sel_test;
    localparam int WAYS = 16, SETS = 4, SIG_W = 10;
    localparam int NSIG = 1 << SIG_W;

    logic clk = 1'b0, rst = 1'b1;
    logic acc_valid = 1'b0, acc_hit = 1'b0;
    logic [SIG_W-1:0] acc_sig = '0;
    logic [1:0] acc_set = '0;
    logic [3:0] acc_way = '0;
    logic pred_valid, pred_hit, vic_valid;
    logic [3:0] vic_way;
    logic [1:0] vic_reason;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    bit m_valid [SETS][WAYS];
    bit m_flag  [SETS][WAYS];
    int m_rank  [SETS][WAYS];
    int m_ctr   [NSIG];

    always #4 clk = ~clk;

    miss_aware_victim_sel #(.WAYS(WAYS), .SETS(SETS), .SIG_W(SIG_W), .CTR_W(3)) uut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sig(acc_sig),
        .acc_set(acc_set), .acc_hit(acc_hit), .acc_way(acc_way),
        .pred_valid(pred_valid), .pred_hit(pred_hit), .vic_valid(vic_valid),
        .vic_way(vic_way), .vic_reason(vic_reason)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected victim from requirements R1, R5, R6
    function automatic void exp_victim(input int s, output int w, output int r);
        int best;
        w = -1; r = 0;
        for (int i = 0; i < WAYS; i++)
            if (!m_valid[s][i] && w < 0) w = i;
        if (w >= 0) return;
        best = -1;
        for (int i = 0; i < WAYS; i++)
            if (!m_flag[s][i] && m_rank[s][i] > best) begin best = m_rank[s][i]; w = i; end
        if (w >= 0) begin r = 1; return; end
        for (int i = 0; i < WAYS; i++)
            if (m_rank[s][i] == WAYS - 1) w = i;
        r = 2;
    endfunction

    task automatic access(input int sig, input int s, input bit hit, input int way);
        int ew, er, t, old;
        bit ep;
        ep = (m_ctr[sig] >= 4);
        exp_victim(s, ew, er);
        acc_valid = 1'b1; acc_sig = SIG_W'(sig); acc_set = 2'(s); acc_hit = hit;
        acc_way = hit ? 4'(way) : 4'($urandom_range(0, 15));   // R9: ignored on miss
        @(negedge clk);
        acc_valid = 1'b0;
        check(pred_valid == 1'b1, "R3 pred_valid", int'(pred_valid), 1);
        check(pred_hit == ep, "R2/R3 pred_hit", int'(pred_hit), int'(ep));
        check(vic_valid == !hit, "R4 vic_valid", int'(vic_valid), int'(!hit));
        if (!hit) begin
            if (er == 0)      check(vic_way == 4'(ew), "R1 invalid-first way", int'(vic_way), ew);
            else if (er == 1) check(vic_way == 4'(ew), "R5 miss-predicted way", int'(vic_way), ew);
            else              check(vic_way == 4'(ew), "R6 oldest way", int'(vic_way), ew);
            check(vic_reason == 2'(er), "R1/R5/R6 reason", int'(vic_reason), er);
        end
        // model update per R2, R7, R8
        t = hit ? way : ew;
        old = m_rank[s][t];
        for (int j = 0; j < WAYS; j++)
            if (j != t && m_rank[s][j] < old) m_rank[s][j]++;
        m_rank[s][t] = 0;
        m_valid[s][t] = 1'b1;
        m_flag[s][t] = ep;
        if (hit && m_ctr[sig] < 7) m_ctr[sig]++;
        if (!hit && m_ctr[sig] > 0) m_ctr[sig]--;
    endtask

    task automatic idle_cycle();
        acc_valid = 1'b0;
        acc_sig = SIG_W'($urandom); acc_set = 2'($urandom); acc_hit = 1'($urandom);
        acc_way = 4'($urandom);
        @(negedge clk);
        check(pred_valid == 1'b0, "R9 idle pred_valid", int'(pred_valid), 0);
        check(vic_valid == 1'b0, "R9 idle vic_valid", int'(vic_valid), 0);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                m_valid[s][w] = 1'b0; m_flag[s][w] = 1'b0; m_rank[s][w] = w;   // R7 initial rank
            end
        for (int i = 0; i < NSIG; i++) m_ctr[i] = 4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(pred_valid == 1'b0, "R4 reset pred_valid", int'(pred_valid), 0);
        check(vic_valid == 1'b0, "R4 reset vic_valid", int'(vic_valid), 0);

        // R1: fill set 0 in way order
        for (int i = 0; i < WAYS; i++) access(100 + i, 0, 1'b0, 0);
        // R2: saturation of signature 9 (6 hits, then misses)
        for (int i = 0; i < 6; i++) access(9, 0, 1'b1, i);
        for (int i = 0; i < 5; i++) access(9, 3, 1'b0, 0);
        // R6: set 2 full of hit-friendly lines, victim is the oldest
        for (int i = 0; i < WAYS; i++) access(200 + i, 2, 1'b0, 0);
        access(300, 2, 1'b0, 0);
        // R5: make a young line miss-predicted, it is evicted first
        access(400, 1, 1'b0, 0);
        access(400, 1, 1'b0, 0);
        access(400, 2, 1'b1, 5);
        access(301, 2, 1'b0, 0);
        // R9: idle cycles change nothing
        for (int i = 0; i < 20; i++) idle_cycle();
        access(302, 2, 1'b0, 0);
        // mixed stream
        for (int n = 0; n < 6000; n++) begin
            int s, w, sig;
            s = $urandom_range(0, SETS - 1);
            w = $urandom_range(0, WAYS - 1);
            sig = $urandom_range(0, 23);
            if (n % 37 == 0) idle_cycle();
            if (($urandom_range(0, 2) != 0) && m_valid[s][w]) access(sig, s, 1'b1, w);
            else access(sig, s, 1'b0, 0);
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule